// File: doc/BRIEF.md
# MSI Capture and Interrupt Status Unit

This unit watches the stream of inbound memory writes arriving from a link and picks out those that are message-signalled interrupts. A write counts as an interrupt message when it lands exactly on a programmable 64-bit target address. Its data word carries the vector number directly. The unit supports 64 vectors, held as two 32-bit banks of pending bits. Vectors 0 to 31 go to the low bank and vectors 32 to 63 go to the high bank. Each bank has its own enable mask and drives its own interrupt line.

Software reaches the unit through a simple single-cycle register port. Writes take effect on the clock edge, and the read data is combinational from the address. Through this port software programs the target address, the two masks and the control bits. It reads the pending words and retires handled vectors by writing ones to them.

Top module: `msi_capture_unit`

## Requirements
- R1: After reset the control, target address, pending and mask words all read 0, both interrupt lines are low, and the capability word (offset 0x00) reads 1 (presence flag in bit 0).
- R2: The register port uses 32-bit byte offsets: 0x00 capability (read only), 0x04 control, 0x08 target address bits 31:0, 0x0C target address bits 63:32, 0x10 low pending, 0x14 high pending, 0x18 low mask, 0x1C high mask. Only control bits 0 (capture enable) and 15 (report enable) are stored, and the other control bits read 0.
- R3: An accepted message with data v sets pending bit v of the low word when v < 32, and bit v-32 of the high word when 32 <= v <= 63. The bit is visible from the clock edge that samples the write.
- R4: A message is accepted only when control bit 0 is set and all 64 address bits equal the target address. Any other inbound write leaves both pending words unchanged.
- R5: An inbound write whose data is 64 or more leaves both pending words unchanged, including when its low six bits name a valid vector.
- R6: Writing the low or high pending word clears exactly the bits written as 1. Bits written as 0 and the other word keep their values.
- R7: Each interrupt line is high while its bank's pending word ANDed with that bank's mask word is nonzero (mask bit 1 enables the vector). The two lines are independent, and an all-zero mask silences its bank.
- R8: While control bit 15 is clear, both interrupt lines are held low, and pending bits are still latched.
- R9: When a message and a software clear reach the same pending bit in the same cycle, the bit ends set. Other bits named in that clear are cleared.
- R10: A message for a masked vector still sets its pending bit. Enabling that vector's mask bit later raises the bank's line while the bit stays pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_wr_valid | input | 1 | Inbound memory write present this cycle |
| in_wr_addr | input | 64 | Inbound write address |
| in_wr_data | input | 32 | Inbound write data (vector number for a message) |
| reg_wr | input | 1 | Register port write strobe |
| reg_addr | input | 6 | Register port byte offset |
| reg_wdata | input | 32 | Register port write data |
| reg_rdata | output | 32 | Register port read data for reg_addr |
| irq_lo | output | 1 | Interrupt line of vectors 0 to 31 |
| irq_hi | output | 1 | Interrupt line of vectors 32 to 63 |

## Verification
Two functions can land in the same cycle: capturing an inbound message into a pending bit, and a software write-one-to-clear of that same pending word. The bench provokes this by driving a matching inbound write and a pending-word register write on one clock edge. The clear names both the captured vector and a neighbouring pending vector. The result counts as correct only if the captured bit survives while the neighbour is cleared.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;

    // Word index of the register port (byte offset divided by four)
    typedef enum logic [3:0] {
        RG_CAP     = 4'd0,
        RG_CTRL    = 4'd1,
        RG_BASE_LO = 4'd2,
        RG_BASE_HI = 4'd3,
        RG_STAT_LO = 4'd4,
        RG_STAT_HI = 4'd5,
        RG_MASK_LO = 4'd6,
        RG_MASK_HI = 4'd7
    } reg_idx_e;

    localparam int CTRL_CAPTURE_BIT = 0;
    localparam int CTRL_REPORT_BIT  = 15;
    localparam int CAP_PRESENT_BIT  = 0;

endpackage

// File: rtl/msi_match.sv
module msi_match #(
    parameter int ADDR_W  = 64,
    parameter int DATA_W  = 32,
    parameter int NUM_VEC = 64
) (
    input  logic                in_valid,
    input  logic [ADDR_W-1:0]   in_addr,
    input  logic [DATA_W-1:0]   in_data,
    input  logic [ADDR_W-1:0]   base_addr,
    input  logic                cap_en,
    output logic [NUM_VEC-1:0]  set_vec
);
    localparam int VEC_W = $clog2(NUM_VEC);

    logic hit;

    always_comb begin
        hit = in_valid && cap_en && (in_addr == base_addr)
              && (in_data < DATA_W'(NUM_VEC));
    end

    for (genvar i = 0; i < NUM_VEC; i++) begin : g_dec
        assign set_vec[i] = hit && (in_data[VEC_W-1:0] == VEC_W'(i));
    end

endmodule

// File: rtl/msi_bank.sv
module msi_bank #(
    parameter int BANK_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] set_bits,
    input  logic [BANK_W-1:0] clr_bits,
    input  logic              mask_we,
    input  logic [BANK_W-1:0] mask_wdata,
    input  logic              report_en,
    output logic [BANK_W-1:0] status,
    output logic [BANK_W-1:0] mask,
    output logic              irq
);
    logic [BANK_W-1:0] status_nxt;

    always_comb begin
        // capture takes precedence over a clear of the same bit
        status_nxt = (status & ~clr_bits) | set_bits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status <= '0;
            mask   <= '0;
        end else begin
            status <= status_nxt;
            if (mask_we) begin
                mask <= mask_wdata;
            end
        end
    end

    assign irq = report_en && (|(status & mask));

endmodule

// File: rtl/msi_regs.sv
module msi_regs
    import msi_cap_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int REG_AW = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [REG_AW-1:0]    reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    input  logic [2*DATA_W-1:0]  status_flat,
    input  logic [2*DATA_W-1:0]  mask_flat,
    output logic                 cap_en,
    output logic                 report_en,
    output logic [2*DATA_W-1:0]  base_addr,
    output logic [2*DATA_W-1:0]  stat_clr,
    output logic [1:0]           mask_we,
    output logic [DATA_W-1:0]    reg_rdata
);
    logic [3:0]        idx;
    logic [DATA_W-1:0] base_lo_q;
    logic [DATA_W-1:0] base_hi_q;
    logic              cap_en_q;
    logic              report_en_q;
    logic [1:0]        unused_addr;

    assign idx         = reg_addr[5:2];
    assign unused_addr = reg_addr[1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_lo_q   <= '0;
            base_hi_q   <= '0;
            cap_en_q    <= 1'b0;
            report_en_q <= 1'b0;
        end else if (reg_wr) begin
            unique case (idx)
                RG_CTRL: begin
                    cap_en_q    <= reg_wdata[CTRL_CAPTURE_BIT];
                    report_en_q <= reg_wdata[CTRL_REPORT_BIT];
                end
                RG_BASE_LO: base_lo_q <= reg_wdata;
                RG_BASE_HI: base_hi_q <= reg_wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        stat_clr = '0;
        mask_we  = 2'b00;
        if (reg_wr) begin
            unique case (idx)
                RG_STAT_LO: stat_clr[DATA_W-1:0]        = reg_wdata;
                RG_STAT_HI: stat_clr[2*DATA_W-1:DATA_W] = reg_wdata;
                RG_MASK_LO: mask_we[0] = 1'b1;
                RG_MASK_HI: mask_we[1] = 1'b1;
                default: ;
            endcase
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (idx)
            RG_CAP:     reg_rdata[CAP_PRESENT_BIT] = 1'b1;
            RG_CTRL: begin
                reg_rdata[CTRL_CAPTURE_BIT] = cap_en_q;
                reg_rdata[CTRL_REPORT_BIT]  = report_en_q;
            end
            RG_BASE_LO: reg_rdata = base_lo_q;
            RG_BASE_HI: reg_rdata = base_hi_q;
            RG_STAT_LO: reg_rdata = status_flat[DATA_W-1:0];
            RG_STAT_HI: reg_rdata = status_flat[2*DATA_W-1:DATA_W];
            RG_MASK_LO: reg_rdata = mask_flat[DATA_W-1:0];
            RG_MASK_HI: reg_rdata = mask_flat[2*DATA_W-1:DATA_W];
            default:    reg_rdata = '0;
        endcase
    end

    assign cap_en    = cap_en_q;
    assign report_en = report_en_q;
    assign base_addr = {base_hi_q, base_lo_q};

endmodule

// File: rtl/msi_capture_unit.sv
module msi_capture_unit #(
    parameter int DATA_W = 32,
    parameter int REG_AW = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_wr_valid,
    input  logic [2*DATA_W-1:0] in_wr_addr,
    input  logic [DATA_W-1:0]   in_wr_data,
    input  logic                reg_wr,
    input  logic [REG_AW-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic                irq_lo,
    output logic                irq_hi
);
    localparam int BANK_W    = DATA_W;
    localparam int NUM_BANKS = 2;
    localparam int NUM_VEC   = BANK_W * NUM_BANKS;
    localparam int ADDR_W    = 2 * DATA_W;

    logic                 cap_en;
    logic                 report_en;
    logic [ADDR_W-1:0]    base_addr;
    logic [NUM_VEC-1:0]   set_vec;
    logic [NUM_VEC-1:0]   stat_clr;
    logic [NUM_VEC-1:0]   status_flat;
    logic [NUM_VEC-1:0]   mask_flat;
    logic [NUM_BANKS-1:0] mask_we;
    logic [NUM_BANKS-1:0] irq_vec;
    logic [BANK_W-1:0]    status_lo_w;
    logic [BANK_W-1:0]    status_hi_w;

    msi_regs #(
        .DATA_W (DATA_W),
        .REG_AW (REG_AW)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr      (reg_wr),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .status_flat (status_flat),
        .mask_flat   (mask_flat),
        .cap_en      (cap_en),
        .report_en   (report_en),
        .base_addr   (base_addr),
        .stat_clr    (stat_clr),
        .mask_we     (mask_we),
        .reg_rdata   (reg_rdata)
    );

    msi_match #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .NUM_VEC (NUM_VEC)
    ) u_match (
        .in_valid  (in_wr_valid),
        .in_addr   (in_wr_addr),
        .in_data   (in_wr_data),
        .base_addr (base_addr),
        .cap_en    (cap_en),
        .set_vec   (set_vec)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        msi_bank #(
            .BANK_W (BANK_W)
        ) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .set_bits   (set_vec[b*BANK_W +: BANK_W]),
            .clr_bits   (stat_clr[b*BANK_W +: BANK_W]),
            .mask_we    (mask_we[b]),
            .mask_wdata (reg_wdata),
            .report_en  (report_en),
            .status     (status_flat[b*BANK_W +: BANK_W]),
            .mask       (mask_flat[b*BANK_W +: BANK_W]),
            .irq        (irq_vec[b])
        );
    end

    assign status_lo_w = status_flat[BANK_W-1:0];
    assign status_hi_w = status_flat[NUM_VEC-1:BANK_W];
    assign irq_lo      = irq_vec[0];
    assign irq_hi      = irq_vec[NUM_BANKS-1];

endmodule

// File: rtl/msi_cap_checker.sv
module msi_cap_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        in_wr_valid,
    input logic [63:0] in_wr_addr,
    input logic [31:0] in_wr_data,
    input logic        reg_wr,
    input logic [5:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input logic        cap_en,
    input logic        report_en,
    input logic [63:0] base_addr,
    input logic [31:0] status_lo,
    input logic [31:0] status_hi,
    input logic        irq_lo,
    input logic        irq_hi
);
    logic accept;
    logic clr_lo_wr;

    assign accept    = in_wr_valid && cap_en && (in_wr_addr == base_addr) && (in_wr_data < 32'd64);
    assign clr_lo_wr = reg_wr && (reg_addr[5:2] == 4'd4);

    AST_CAPTURE_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && in_wr_data < 32'd32) |=> status_lo[$past(in_wr_data[4:0])]); // R3

    AST_CAPTURE_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && in_wr_data >= 32'd32) |=> status_hi[$past(in_wr_data[4:0])]); // R3

    AST_DISABLED_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_wr_valid && !cap_en && !reg_wr) |=> $stable({status_hi, status_lo})); // R4

    AST_RANGE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_wr_valid && in_wr_data >= 32'd64 && !reg_wr) |=> $stable({status_hi, status_lo})); // R5

    AST_W1C_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_lo_wr && !(accept && in_wr_data < 32'd32)) |=> ((status_lo & $past(reg_wdata)) == 32'd0)); // R6

    AST_REPORT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !report_en |-> (!irq_lo && !irq_hi)); // R8

    AST_CAPTURE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_lo_wr && accept && in_wr_data < 32'd32) |=> status_lo[$past(in_wr_data[4:0])]); // R9

endmodule

bind msi_capture_unit msi_cap_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_wr_valid (in_wr_valid),
    .in_wr_addr  (in_wr_addr),
    .in_wr_data  (in_wr_data),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .cap_en      (cap_en),
    .report_en   (report_en),
    .base_addr   (base_addr),
    .status_lo   (status_lo_w),
    .status_hi   (status_hi_w),
    .irq_lo      (irq_lo),
    .irq_hi      (irq_hi)
);

// File: tb/msi_capture_unit_bench.sv
`timescale 1ns/100ps
module msi_capture_unit_bench;

    localparam logic [5:0] A_CAP = 6'h00, A_CTRL = 6'h04, A_BLO = 6'h08, A_BHI = 6'h0C,
                           A_SLO = 6'h10, A_SHI = 6'h14, A_MLO = 6'h18, A_MHI = 6'h1C;
    localparam logic [63:0] TGT = 64'hFEE0_1234_0000_4000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_wr_valid = 1'b0;
    logic [63:0] in_wr_addr = '0;
    logic [31:0] in_wr_data = '0;
    logic        reg_wr = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_lo;
    logic        irq_hi;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;

    always #2.5 clk = ~clk;

    msi_capture_unit u_msi_capture_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_wr_valid (in_wr_valid),
        .in_wr_addr  (in_wr_addr),
        .in_wr_data  (in_wr_data),
        .reg_wr      (reg_wr),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .irq_lo      (irq_lo),
        .irq_hi      (irq_hi)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr_reg(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #0.5 d = reg_rdata;
    endtask

    task automatic send_msg(input logic [63:0] a, input logic [31:0] d);
        @(negedge clk);
        in_wr_valid = 1'b1; in_wr_addr = a; in_wr_data = d;
        @(posedge clk); #1;
        in_wr_valid = 1'b0;
    endtask

    task automatic expect_status(input string tag, input logic [31:0] lo, input logic [31:0] hi);
        logic [31:0] v;
        rd_reg(A_SLO, v); check({tag, " low word"}, v, lo);
        rd_reg(A_SHI, v); check({tag, " high word"}, v, hi);
    endtask

    task automatic clear_all();
        wr_reg(A_SLO, 32'hFFFF_FFFF);
        wr_reg(A_SHI, 32'hFFFF_FFFF);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 irq_lo after reset", {31'd0, irq_lo}, 32'd0);
        check("R1 irq_hi after reset", {31'd0, irq_hi}, 32'd0);
        rd_reg(A_CAP, v);  check("R1 capability", v, 32'd1);
        rd_reg(A_CTRL, v); check("R1 control", v, 32'd0);
        rd_reg(A_BLO, v);  check("R1 target low", v, 32'd0);
        rd_reg(A_BHI, v);  check("R1 target high", v, 32'd0);
        rd_reg(A_MLO, v);  check("R1 mask low", v, 32'd0);
        rd_reg(A_MHI, v);  check("R1 mask high", v, 32'd0);
        expect_status("R1 pending", 32'd0, 32'd0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        wr_reg(A_CTRL, 32'hFFFF_FFFF);
        rd_reg(A_CTRL, v); check("R2 control keeps bits 0 and 15", v, 32'h0000_8001);
        wr_reg(A_CTRL, 32'd0);
        wr_reg(A_BLO, TGT[31:0]);
        wr_reg(A_BHI, TGT[63:32]);
        rd_reg(A_BLO, v); check("R2 target low readback", v, TGT[31:0]);
        rd_reg(A_BHI, v); check("R2 target high readback", v, TGT[63:32]);
        wr_reg(A_MLO, 32'hA5A5_0F0F);
        rd_reg(A_MLO, v); check("R2 mask low readback", v, 32'hA5A5_0F0F);
        wr_reg(A_MHI, 32'hFFFF_FFFF);
        wr_reg(A_MLO, 32'hFFFF_FFFF);
        wr_reg(A_CTRL, 32'h0000_8001);
    endtask

    task automatic t_capture();
        send_msg(TGT, 32'd0);
        check("R3 vector 0 irq_lo", {31'd0, irq_lo}, 32'd1);
        check("R7 vector 0 leaves irq_hi low", {31'd0, irq_hi}, 32'd0);
        send_msg(TGT, 32'd31);
        expect_status("R3 vectors 0 and 31", 32'h8000_0001, 32'd0);
        send_msg(TGT, 32'd32);
        check("R7 vector 32 irq_hi", {31'd0, irq_hi}, 32'd1);
        send_msg(TGT, 32'd63);
        expect_status("R3 vectors 32 and 63", 32'h8000_0001, 32'h8000_0001);
        clear_all();
        expect_status("R6 clear all", 32'd0, 32'd0);
        check("R7 irq_lo low when nothing pending", {31'd0, irq_lo}, 32'd0);
        check("R7 irq_hi low when nothing pending", {31'd0, irq_hi}, 32'd0);
    endtask

    task automatic t_ignore();
        send_msg(TGT ^ 64'h0000_0001_0000_0000, 32'd4);
        expect_status("R4 high address bit differs", 32'd0, 32'd0);
        send_msg(TGT ^ 64'h4, 32'd4);
        expect_status("R4 low address bit differs", 32'd0, 32'd0);
        wr_reg(A_CTRL, 32'h0000_8000);
        send_msg(TGT, 32'd4);
        expect_status("R4 capture disabled", 32'd0, 32'd0);
        wr_reg(A_CTRL, 32'h0000_8001);
        send_msg(TGT, 32'd64);
        send_msg(TGT, 32'h0000_0100);
        send_msg(TGT, 32'hFFFF_FFFF);
        expect_status("R5 data 64 and above", 32'd0, 32'd0);
        check("R5 irq_lo stays low", {31'd0, irq_lo}, 32'd0);
    endtask

    task automatic t_w1c();
        send_msg(TGT, 32'd3);
        send_msg(TGT, 32'd7);
        send_msg(TGT, 32'd40);
        wr_reg(A_SLO, 32'h0000_0008);
        expect_status("R6 single bit clear", 32'h0000_0080, 32'h0000_0100);
        wr_reg(A_SLO, 32'd0);
        expect_status("R6 zero write keeps bits", 32'h0000_0080, 32'h0000_0100);
        clear_all();
    endtask

    task automatic t_mask();
        wr_reg(A_MLO, 32'd0);
        send_msg(TGT, 32'd9);
        expect_status("R10 masked vector latched", 32'h0000_0200, 32'd0);
        check("R7 all-zero mask silences low", {31'd0, irq_lo}, 32'd0);
        send_msg(TGT, 32'd33);
        check("R7 high line independent", {31'd0, irq_hi}, 32'd1);
        wr_reg(A_MLO, 32'h0000_0200);
        check("R10 unmask raises irq_lo", {31'd0, irq_lo}, 32'd1);
        wr_reg(A_MLO, 32'h0000_0100);
        check("R7 other mask bit keeps irq_lo low", {31'd0, irq_lo}, 32'd0);
        wr_reg(A_MHI, 32'd0);
        check("R7 high mask zero drops irq_hi", {31'd0, irq_hi}, 32'd0);
        wr_reg(A_MLO, 32'hFFFF_FFFF);
        wr_reg(A_MHI, 32'hFFFF_FFFF);
        clear_all();
    endtask

    task automatic t_report();
        wr_reg(A_CTRL, 32'h0000_0001);
        send_msg(TGT, 32'd12);
        send_msg(TGT, 32'd50);
        check("R8 report off holds irq_lo low", {31'd0, irq_lo}, 32'd0);
        check("R8 report off holds irq_hi low", {31'd0, irq_hi}, 32'd0);
        expect_status("R8 still latched", 32'h0000_1000, 32'h0004_0000);
        wr_reg(A_CTRL, 32'h0000_8001);
        check("R8 report on releases irq_lo", {31'd0, irq_lo}, 32'd1);
        clear_all();
    endtask

    task automatic t_collide();
        send_msg(TGT, 32'd21);
        @(negedge clk);
        in_wr_valid = 1'b1; in_wr_addr = TGT; in_wr_data = 32'd20;
        reg_wr = 1'b1; reg_addr = A_SLO; reg_wdata = 32'h0030_0000;
        @(posedge clk); #1;
        in_wr_valid = 1'b0; reg_wr = 1'b0;
        expect_status("R9 capture beats clear", 32'h0010_0000, 32'd0);
        check("R9 irq_lo after collision", {31'd0, irq_lo}, 32'd1);
        clear_all();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_regs();
        t_capture();
        t_ignore();
        t_w1c();
        t_mask();
        t_report();
        t_collide();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule